// File: doc/BRIEF.md
# Accessed/Dirty Assist Controller

This block sits between a small data translation cache and a page-table walker. It decides whether a memory micro-op can finish its address translation while it is still speculative, or whether the page entry's accessed or dirty flag must first be set. Setting those flags is a side effect. A side effect of that kind may only happen once the micro-op is no longer speculative.

A lookup that hits the translation cache completes at once. A miss, or a store that hits an entry not yet marked dirty, starts a walk. The walker is modelled here as a responder with a fixed latency, backed by a flag table. When the walk finds that no flag needs setting, the translation completes and the cache is filled. When a flag must be set and the micro-op is speculative, the micro-op is sent back for redispatch and a pending-update record is kept. The page-entry write happens only when that micro-op retires, and the cache is then refilled with the new flags. A flush drops the record without any write. A non-speculative micro-op gets its update written at once. Only one record may exist at a time.

Top module: `ad_assist_ctrl`

## Requirements
- R1: A request whose page is present in the translation cache (and, for a store, marked dirty there) raises `done_o` in the cycle after it is accepted, with no walk.
- R2: Any other request starts a walk. If the walk needs no flag update, `done_o` rises WALK_LAT+1 cycles after acceptance and the cache is filled with that translation.
- R3: The physical page reported on `done_ppn_o` is the virtual page zero-extended to 8 bits, XORed with 8'hA5. At reset, the walker's accessed flag equals bit 0 of the virtual page and its dirty flag equals bit 1.
- R4: A speculative request that finds the accessed flag clear, or a speculative store that finds the dirty flag clear, raises `redispatch_o` WALK_LAT+1 cycles after acceptance. It raises no `done_o` and causes no page-entry write.
- R5: When `retire_i` is high while an update is pending, `pte_wr_valid_o` pulses in the next cycle. `pte_wr_vpn_o` carries the pending page, and `pte_wr_dirty_o` is 1 if the micro-op was a store or the page was already dirty. The accessed flag is always set by this write.
- R6: When `flush_i` is high while an update is pending, the record is dropped and no page-entry write follows. Flush wins over a retire in the same cycle.
- R7: After a retirement-time update, replaying the same micro-op hits in the cache (R1 timing). The walker keeps the updated flags for later walks.
- R8: A non-speculative request that needs a flag update gets `done_o` and `pte_wr_valid_o` in the same cycle, WALK_LAT+1 cycles after acceptance.
- R9: While an update is pending, a second request that needs an update is held. During that time `req_ready_o` is low and it produces no result. Within two cycles after the pending record is retired or flushed, the held request is resolved. Cache hits that arrive while only the record is pending are still served normally.
- R10: `retire_i` with no update pending causes no page-entry write.
- R11: After reset, `done_o`, `redispatch_o` and `pte_wr_valid_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_vpn_i | input | 6 | Virtual page of the request |
| req_store_i | input | 1 | 1 for store, 0 for load |
| req_spec_i | input | 1 | 1 while the micro-op is still speculative |
| req_ready_o | output | 1 | Controller can accept a request |
| retire_i | input | 1 | Micro-op holding the pending update retires |
| flush_i | input | 1 | Micro-op holding the pending update is flushed |
| done_o | output | 1 | Translation complete (one-cycle pulse) |
| done_ppn_o | output | 8 | Physical page for `done_o` |
| redispatch_o | output | 1 | Micro-op sent back with a pending update |
| pte_wr_valid_o | output | 1 | Page-entry flag write |
| pte_wr_vpn_o | output | 6 | Page being written |
| pte_wr_dirty_o | output | 1 | Dirty flag value written (accessed is always set) |

## Verification
A corrupted pending record shows up one cycle after the next retire: either as a page-entry write to the wrong page or with the wrong dirty value, or as a write after a flush. A record that never clears leaves `req_ready_o` stuck low as soon as a second request needs an update. If the cache is not refilled after an update, the very next replay of the same page takes WALK_LAT+1 cycles instead of one, or redispatches a second time. A sequencer that mixes up the speculative and non-speculative paths gives a `done_o` where `redispatch_o` was due, or a write without a retire, on the cycle the walk returns.

// File: rtl/ad_pkg.sv
package ad_pkg;
  localparam int VPN_W = 6;
  localparam int PPN_W = 8;
  localparam logic [PPN_W-1:0] PPN_KEY = 8'hA5;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_STALL} ad_state_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             dirty;
  } xlat_t;

  function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
    return PPN_W'(v) ^ PPN_KEY;
  endfunction

  function automatic logic init_acc(input logic [VPN_W-1:0] v);
    return v[0];
  endfunction

  function automatic logic init_dirty(input logic [VPN_W-1:0] v);
    return v[1];
  endfunction

  // an update is needed when the accessed flag is clear, or a store meets a clean page
  function automatic logic needs_update(input logic acc, input logic dirty, input logic store);
    return !acc || (store && !dirty);
  endfunction
endpackage

// File: rtl/ad_walk_model.sv
module ad_walk_model
  import ad_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_dirty,
  output logic             rsp_valid,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_acc,
  output logic             rsp_dirty
);
  localparam int PAGES = 1 << VPN_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PAGES-1:0] acc_tbl, dirty_tbl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vpn_q <= '0;
      for (int p = 0; p < PAGES; p++) begin
        acc_tbl[p]   <= init_acc(VPN_W'(p));
        dirty_tbl[p] <= init_dirty(VPN_W'(p));
      end
    end else begin
      if (start) begin
        cnt_q <= CNT_W'(LAT);
        vpn_q <= start_vpn;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (wr_en) begin
        acc_tbl[wr_vpn]   <= 1'b1;
        dirty_tbl[wr_vpn] <= dirty_tbl[wr_vpn] | wr_dirty;
      end
    end
  end

  assign rsp_valid = (cnt_q == CNT_W'(1));
  assign rsp_ppn   = ppn_of(vpn_q);
  assign rsp_acc   = acc_tbl[vpn_q];
  assign rsp_dirty = dirty_tbl[vpn_q];

  // R2: a new walk is only started once the previous one has answered
  assert_walk_idle_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));
endmodule

// File: rtl/ad_tlb.sv
module ad_tlb
  import ad_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  xlat_t            fill
);
  localparam int ENTRIES = 1 << IDX_W;

  xlat_t              ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  xlat_t              sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[e] <= 1'b0;
        ent[e] <= '0;
      end else if (fill_en && (fill.vpn[IDX_W-1:0] == IDX_W'(e))) begin
        vld[e] <= 1'b1;
        ent[e] <= fill;
      end
    end
  end

  assign sel    = ent[lk_vpn[IDX_W-1:0]];
  assign lk_hit = vld[lk_vpn[IDX_W-1:0]] && (sel.vpn == lk_vpn) && (!lk_store || sel.dirty);
  assign lk_ppn = sel.ppn;
endmodule

// File: rtl/ad_pend_rec.sv
module ad_pend_rec
  import ad_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  xlat_t set_data,
  input  logic  retire,
  input  logic  flush,
  output logic  valid,
  output xlat_t data,
  output logic  fire
);
  assign fire = valid && retire && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (set_en) begin
      valid <= 1'b1;
      data  <= set_data;
    end else if (valid && (retire || flush)) begin
      valid <= 1'b0;
    end
  end

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !valid);
  assert_flush_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && flush) |=> !valid);
endmodule

// File: rtl/ad_assist_ctrl.sv
module ad_assist_ctrl
  import ad_pkg::*;
#(
  parameter int WALK_LAT  = 4,
  parameter int TLB_IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_store_i,
  input  logic             req_spec_i,
  output logic             req_ready_o,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic             done_o,
  output logic [PPN_W-1:0] done_ppn_o,
  output logic             redispatch_o,
  output logic             pte_wr_valid_o,
  output logic [VPN_W-1:0] pte_wr_vpn_o,
  output logic             pte_wr_dirty_o
);
  ad_state_e        state_q, state_d;
  logic [VPN_W-1:0] cur_vpn_q;
  logic             cur_st_q, cur_spec_q;
  logic [PPN_W-1:0] sv_ppn_q;
  logic             sv_acc_q, sv_dirty_q;

  // named internal events
  logic             accept_w, tlb_hit_w, hit_done_w, walk_start_w;
  logic             rsp_valid_w, rsp_acc_w, rsp_dirty_w;
  logic [PPN_W-1:0] tlb_ppn_w, rsp_ppn_w;
  logic             resolve_w, need_w, go_stall_w, plain_done_w, imm_fix_w, park_w;
  logic [PPN_W-1:0] res_ppn_w;
  logic             res_acc_w, res_dirty_w, new_dirty_w;
  logic             pend_valid_w, pend_fire_w;
  xlat_t            pend_data_w, cur_xlat_w, tlb_fill_w;
  logic             tlb_fill_en_w, pt_wr_en_w;

  assign req_ready_o  = (state_q == S_IDLE);
  assign accept_w     = req_ready_o && req_valid_i;
  assign hit_done_w   = accept_w && tlb_hit_w;
  assign walk_start_w = accept_w && !tlb_hit_w;

  // outcome of a walk: fresh from the walker, or replayed from the saved copy after a stall
  assign resolve_w    = ((state_q == S_WALK) && rsp_valid_w) || ((state_q == S_STALL) && !pend_valid_w);
  assign res_ppn_w    = (state_q == S_WALK) ? rsp_ppn_w   : sv_ppn_q;
  assign res_acc_w    = (state_q == S_WALK) ? rsp_acc_w   : sv_acc_q;
  assign res_dirty_w  = (state_q == S_WALK) ? rsp_dirty_w : sv_dirty_q;
  assign need_w       = needs_update(res_acc_w, res_dirty_w, cur_st_q);
  assign new_dirty_w  = res_dirty_w | cur_st_q;
  assign go_stall_w   = resolve_w && need_w && pend_valid_w;
  assign plain_done_w = resolve_w && !need_w;
  assign imm_fix_w    = resolve_w && need_w && !pend_valid_w && !cur_spec_q;
  assign park_w       = resolve_w && need_w && !pend_valid_w && cur_spec_q;

  assign cur_xlat_w    = '{vpn: cur_vpn_q, ppn: res_ppn_w, dirty: new_dirty_w};
  assign tlb_fill_en_w = pend_fire_w || plain_done_w || imm_fix_w;
  assign tlb_fill_w    = pend_fire_w ? pend_data_w : cur_xlat_w;
  assign pt_wr_en_w    = pend_fire_w || imm_fix_w;

  ad_tlb #(.IDX_W(TLB_IDX_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn_i), .lk_store(req_store_i), .lk_hit(tlb_hit_w), .lk_ppn(tlb_ppn_w),
    .fill_en(tlb_fill_en_w), .fill(tlb_fill_w)
  );

  ad_walk_model #(.LAT(WALK_LAT)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(walk_start_w), .start_vpn(req_vpn_i),
    .wr_en(pt_wr_en_w),
    .wr_vpn(pend_fire_w ? pend_data_w.vpn : cur_vpn_q),
    .wr_dirty(pend_fire_w ? pend_data_w.dirty : new_dirty_w),
    .rsp_valid(rsp_valid_w), .rsp_ppn(rsp_ppn_w), .rsp_acc(rsp_acc_w), .rsp_dirty(rsp_dirty_w)
  );

  ad_pend_rec u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(park_w), .set_data(cur_xlat_w),
    .retire(retire_i), .flush(flush_i),
    .valid(pend_valid_w), .data(pend_data_w), .fire(pend_fire_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (walk_start_w) state_d = S_WALK;
      S_WALK:  if (rsp_valid_w)  state_d = go_stall_w ? S_STALL : S_IDLE;
      S_STALL: if (!pend_valid_w) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= S_IDLE;
      cur_vpn_q      <= '0;
      cur_st_q       <= 1'b0;
      cur_spec_q     <= 1'b0;
      sv_ppn_q       <= '0;
      sv_acc_q       <= 1'b0;
      sv_dirty_q     <= 1'b0;
      done_o         <= 1'b0;
      done_ppn_o     <= '0;
      redispatch_o   <= 1'b0;
      pte_wr_valid_o <= 1'b0;
      pte_wr_vpn_o   <= '0;
      pte_wr_dirty_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        cur_vpn_q  <= req_vpn_i;
        cur_st_q   <= req_store_i;
        cur_spec_q <= req_spec_i;
      end
      if ((state_q == S_WALK) && rsp_valid_w) begin
        sv_ppn_q   <= rsp_ppn_w;
        sv_acc_q   <= rsp_acc_w;
        sv_dirty_q <= rsp_dirty_w;
      end
      done_o         <= hit_done_w || plain_done_w || imm_fix_w;
      done_ppn_o     <= hit_done_w ? tlb_ppn_w : res_ppn_w;
      redispatch_o   <= park_w;
      pte_wr_valid_o <= pt_wr_en_w;
      pte_wr_vpn_o   <= pend_fire_w ? pend_data_w.vpn : cur_vpn_q;
      pte_wr_dirty_o <= pend_fire_w ? pend_data_w.dirty : new_dirty_w;
    end
  end

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && redispatch_o));
  assert_redispatch_spec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redispatch_o |-> cur_spec_q);
  assert_write_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pte_wr_valid_o |-> ($past(retire_i) || done_o));
  assert_flush_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_w && flush_i) |=> !pte_wr_valid_o);
endmodule

// File: tb/test_ad_assist_ctrl.sv
module test_ad_assist_ctrl;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_store = 1'b0, req_spec = 1'b0;
  logic [5:0] req_vpn = '0;
  logic       retire = 1'b0, flush = 1'b0;
  logic       req_ready_o, done_o, redispatch_o, pte_wr_valid_o, pte_wr_dirty_o;
  logic [7:0] done_ppn_o;
  logic [5:0] pte_wr_vpn_o;

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [5:0] wr_vpn_l = '0;
  logic       wr_d_l = 1'b0;

  always #4 clk = ~clk;

  ad_assist_ctrl #(.WALK_LAT(LAT), .TLB_IDX_W(2)) i_ad_assist_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_vpn_i(req_vpn), .req_store_i(req_store), .req_spec_i(req_spec),
    .req_ready_o(req_ready_o), .retire_i(retire), .flush_i(flush),
    .done_o(done_o), .done_ppn_o(done_ppn_o), .redispatch_o(redispatch_o),
    .pte_wr_valid_o(pte_wr_valid_o), .pte_wr_vpn_o(pte_wr_vpn_o), .pte_wr_dirty_o(pte_wr_dirty_o)
  );

  // page-entry write monitor, sampled shortly after each edge
  always @(posedge clk) begin
    #2;
    if (rst_n && pte_wr_valid_o) begin
      wr_cnt++;
      wr_vpn_l = pte_wr_vpn_o;
      wr_d_l = pte_wr_dirty_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ppn(input logic [5:0] v);
    return int'({2'b00, v} ^ 8'b1010_0101);
  endfunction

  // res: 1 done, 2 redispatch, 0 nothing within maxc cycles
  task automatic run_req(input logic [5:0] v, input logic st, input logic sp, input int maxc,
                         output int res, output int cyc, output int ppn);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_store = st; req_spec = sp;
    @(negedge clk);
    req_valid = 1'b0;
    res = 0; cyc = 1; ppn = 0;
    while (cyc <= maxc) begin
      if (done_o) begin res = 1; ppn = int'(done_ppn_o); break; end
      if (redispatch_o) begin res = 2; break; end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic pulse(input bit do_flush);
    @(negedge clk);
    if (do_flush) flush = 1'b1; else retire = 1'b1;
    @(negedge clk);
    flush = 1'b0; retire = 1'b0;
  endtask

  // {vpn[13:8], store[7], spec[6], kind[5:4] 0 hit/1 walk done/2 redispatch, act[3:2] 0 none/1 retire/2 flush, wr[1], wr_dirty[0]}
  localparam logic [13:0] VEC [14] = '{
    {6'd3, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0},
    {6'd3, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {6'd3, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {6'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0},
    {6'd1, 1'b1, 1'b1, 2'd2, 2'd1, 1'b1, 1'b1},
    {6'd1, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {6'd4, 1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0},
    {6'd4, 1'b0, 1'b1, 2'd2, 2'd1, 1'b1, 1'b0},
    {6'd4, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {6'd8, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1},
    {6'd8, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {6'd6, 1'b1, 1'b1, 2'd2, 2'd1, 1'b1, 1'b1},
    {6'd4, 1'b1, 1'b1, 2'd2, 2'd1, 1'b1, 1'b1},
    {6'd5, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, run hung (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int res, cyc, ppn, w0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 done_o after reset", int'(done_o), 0);
    chk("R11 redispatch_o after reset", int'(redispatch_o), 0);
    chk("R11 pte_wr_valid_o after reset", int'(pte_wr_valid_o), 0);
    chk("R11 req_ready_o after reset", int'(req_ready_o), 1);

    // R10 retire with nothing pending
    w0 = wr_cnt;
    pulse(1'b0);
    @(negedge clk);
    chk("R10 no write without pending", wr_cnt - w0, 0);

    for (int i = 0; i < 14; i++) begin
      logic [5:0] v;
      logic st, sp, wr, wd;
      int kind, act;
      v = VEC[i][13:8]; st = VEC[i][7]; sp = VEC[i][6];
      kind = int'(VEC[i][5:4]); act = int'(VEC[i][3:2]); wr = VEC[i][1]; wd = VEC[i][0];
      w0 = wr_cnt;
      run_req(v, st, sp, 3 * LAT + 8, res, cyc, ppn);
      if (kind == 0) begin
        chk("R1 hit result", res, 1);
        chk("R1 hit latency", cyc, 1);
        chk("R3 ppn on hit", ppn, exp_ppn(v));
        if (i == 5 || i == 8) chk("R7 replay hit after update", cyc, 1);
      end else if (kind == 1) begin
        chk("R2 walk result", res, 1);
        chk("R2 walk latency", cyc, LAT + 1);
        chk("R3 ppn after walk", ppn, exp_ppn(v));
        if (wr) begin
          chk("R8 immediate write count", wr_cnt - w0, 1);
          chk("R8 immediate write page", int'(wr_vpn_l), int'(v));
          chk("R8 immediate write dirty", int'(wr_d_l), int'(wd));
        end else begin
          chk("R2 no write on plain walk", wr_cnt - w0, 0);
        end
      end else begin
        chk("R4 redispatch result", res, 2);
        chk("R4 redispatch latency", cyc, LAT + 1);
        chk("R4 no write while speculative", wr_cnt - w0, 0);
        if (act == 1) begin
          pulse(1'b0);
          chk("R5 write at retire count", wr_cnt - w0, 1);
          chk("R5 write page", int'(wr_vpn_l), int'(v));
          chk("R5 write dirty", int'(wd), int'(wr_d_l));
        end else if (act == 2) begin
          pulse(1'b1);
          @(negedge clk);
          chk("R6 no write after flush", wr_cnt - w0, 0);
        end
      end
    end

    // R9: one outstanding update, second one held
    run_req(6'd16, 1'b0, 1'b1, 3 * LAT + 8, res, cyc, ppn);
    chk("R9 first assist redispatched", res, 2);
    run_req(6'd3, 1'b0, 1'b1, 3 * LAT + 8, res, cyc, ppn);
    chk("R9 hit served while pending", res, 1);
    chk("R9 hit latency while pending", cyc, 1);
    w0 = wr_cnt;
    run_req(6'd32, 1'b0, 1'b1, LAT + 8, res, cyc, ppn);
    chk("R9 second assist held", res, 0);
    chk("R9 ready low while held", int'(req_ready_o), 0);
    pulse(1'b0);
    chk("R9 held walk did not write", wr_cnt - w0, 1);
    chk("R5 retire writes first page", int'(wr_vpn_l), 16);
    res = 0;
    for (int k = 0; k < 3; k++) begin
      if (redispatch_o) res = 2;
      if (res == 0) @(negedge clk);
    end
    chk("R9 held request redispatched after retire", res, 2);
    w0 = wr_cnt;
    pulse(1'b1);
    @(negedge clk);
    chk("R6 flush of second record writes nothing", wr_cnt - w0, 0);
    chk("R9 ready back high", int'(req_ready_o), 1);
    run_req(6'd32, 1'b0, 1'b1, 3 * LAT + 8, res, cyc, ppn);
    chk("R6 flushed page still needs update", res, 2);
    pulse(1'b0);
    chk("R5 late retire write page", int'(wr_vpn_l), 32);
    chk("R5 load keeps dirty clear", int'(wr_d_l), 0);
    run_req(6'd32, 1'b0, 1'b1, 3 * LAT + 8, res, cyc, ppn);
    chk("R7 replay after retire hits", cyc, 1);

    summary();
    $finish;
  end
endmodule